// File: doc/BRIEF.md
# PHY Status and Identifier Read Registers

This block supplies the read side of a small Ethernet PHY management register set: the basic status word at address 1 and the two identifier words at addresses 2 and 3. The PHY core feeds it three live indications: link up, jabber detect and a 100 Mb/s speed flag. A management agent reads it through a plain parallel port made of a 5-bit address, a read strobe and 16-bit read data.

The link bit in the status word latches low: once the link drops, the bit reports 0 until software has seen it through a status read. The jabber bit latches high and is only armed while the PHY runs at 10 Mb/s. Reading the status word re-arms both bits on the following cycle. An event in the same cycle as the read still lands in the latch, so it is never lost. The identifier words are constants. Any other address reads as zero and has no side effects. The read data is combinational from the address and the strobe, and it shows the latched state as it stood before the read.

Top module: `phy_stat_regs`

## Requirements
- R1: After reset the link and jabber latches are 0, so a status read (address 1) returns 0x0009.
- R2: While link_up_i is low at a clock edge, the link bit (status bit 2) becomes 0. It stays 0 after the link returns, until a status read is made.
- R3: After a status read that takes place while the link is up, the link bit reads 1 from the next cycle and follows link_up_i for as long as the link stays up.
- R4: A jabber_i high at a clock edge while speed100_i is 0 sets status bit 1. The bit stays 1 until a status read or a reset.
- R5: jabber_i has no effect on status bit 1 while speed100_i is 1.
- R6: A status read returns the latch values from before the read, and the clear or re-arm takes effect in the next cycle. A link drop or a jabber event in the same cycle as the read still reaches the latch.
- R7: In the status word, bits 0 (extended capability) and 3 (negotiation ability) always read 1, and bits 15:4 read 0.
- R8: A read of address 2 returns 0x0181 (OUI bits 3..18 in bits 15..0).
- R9: A read of address 3 returns 0xB8B1: OUI bits 19..24 = 101110 in bits 15:10, model number 001011 in bits 9:4, revision 0001 in bits 3:0.
- R10: A read of any address other than 1 (0, 2, 3, 4..31) leaves both latched bits unchanged. Addresses other than 1, 2 and 3 return 0x0000.
- R11: mgmt_rdata_o is 0x0000 whenever mgmt_rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_up_i | input | 1 | Live link-valid indication from the PHY core |
| jabber_i | input | 1 | Live jabber-detect indication |
| speed100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| mgmt_addr_i | input | 5 | Management register address |
| mgmt_rd_i | input | 1 | Read strobe, one read per cycle it is high |
| mgmt_rdata_o | output | 16 | Read data, valid in the strobe cycle |

## Verification
The hardest cases to reach from the ports are the ones where an event lands in the same cycle as a status read. A link drop or a jabber pulse has to coincide exactly with the strobe, and the next read must then show that the event survived the clear. The stimulus places both inputs in the strobe cycle and reads again on the next cycle. A second difficult pattern is a link that drops and returns between two reads, which has to read 0 once even though the link is up at the time of the read. A behavioural model in the bench follows every edge and compares the read data on every cycle.

// File: rtl/phy_stat_pkg.sv
package phy_stat_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_ID_HI = 5'd2;
  localparam logic [ADDR_W-1:0] ADDR_ID_LO = 5'd3;

  localparam logic [15:0] ID_HI_VAL = 16'h0181;
  localparam logic [5:0]  OUI_TAIL = 6'b101110;
  localparam logic [5:0]  MODEL_NUM = 6'b001011;
  localparam logic [3:0]  REV_NUM = 4'b0001;

  typedef struct packed {
    logic [11:0] rsvd;
    logic        an_able;
    logic        link;
    logic        jabber;
    logic        ext_cap;
  } stat_word_t;

  typedef struct packed {
    logic [5:0] oui_tail;
    logic [5:0] model;
    logic [3:0] rev;
  } id_lo_word_t;
endpackage

// File: rtl/phy_stat_rst_sync.sv
module phy_stat_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/phy_stat_latch.sv
module phy_stat_latch #(
  parameter bit LATCH_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cond_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;
  logic nxt;
  logic en;

  generate
    if (LATCH_LOW) begin : g_low
      always_comb nxt = cond_i & (q | clr_i);

      // R2
      property drop_clears_p;
        @(posedge clk) disable iff (!rst_n) !cond_i |=> !q;
      endproperty
      link_drop_chk: assert property (drop_clears_p);

      // R2
      property low_holds_p;
        @(posedge clk) disable iff (!rst_n) (!q && !clr_i) |=> !q;
      endproperty
      link_hold_chk: assert property (low_holds_p);
    end else begin : g_high
      always_comb nxt = cond_i | (q & ~clr_i);

      // R4
      property event_sets_p;
        @(posedge clk) disable iff (!rst_n) cond_i |=> q;
      endproperty
      jab_set_chk: assert property (event_sets_p);

      // R4
      property high_holds_p;
        @(posedge clk) disable iff (!rst_n) (q && !clr_i) |=> q;
      endproperty
      jab_hold_chk: assert property (high_holds_p);
    end
  endgenerate

  always_comb en = (nxt != q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/phy_stat_rdmux.sv
module phy_stat_rdmux
  import phy_stat_pkg::*;
(
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              link_q_i,
  input  logic              jab_q_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              stat_clr_o
);
  stat_word_t  sw;
  id_lo_word_t idw;

  always_comb begin
    sw.rsvd    = '0;
    sw.an_able = 1'b1;
    sw.link    = link_q_i;
    sw.jabber  = jab_q_i;
    sw.ext_cap = 1'b1;
    idw.oui_tail = OUI_TAIL;
    idw.model    = MODEL_NUM;
    idw.rev      = REV_NUM;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_STAT:  rdata_o = sw;
        ADDR_ID_HI: rdata_o = ID_HI_VAL;
        ADDR_ID_LO: rdata_o = idw;
        default:    rdata_o = '0;
      endcase
    end
  end

  assign stat_clr_o = rd_i && (addr_i == ADDR_STAT);
endmodule

// File: rtl/phy_stat_regs.sv
module phy_stat_regs
  import phy_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_i,
  input  logic              jabber_i,
  input  logic              speed100_i,
  input  logic [ADDR_W-1:0] mgmt_addr_i,
  input  logic              mgmt_rd_i,
  output logic [DATA_W-1:0] mgmt_rdata_o
);
  logic rst_sync_n;
  logic link_q;
  logic jab_q;
  logic jab_ev;
  logic stat_clr;

  phy_stat_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb jab_ev = jabber_i & ~speed100_i;

  phy_stat_latch #(.LATCH_LOW(1'b1)) u_link (
    .clk(clk), .rst_n(rst_sync_n), .cond_i(link_up_i),
    .clr_i(stat_clr), .q_o(link_q)
  );

  phy_stat_latch #(.LATCH_LOW(1'b0)) u_jab (
    .clk(clk), .rst_n(rst_sync_n), .cond_i(jab_ev),
    .clr_i(stat_clr), .q_o(jab_q)
  );

  phy_stat_rdmux u_mux (
    .rd_i(mgmt_rd_i), .addr_i(mgmt_addr_i), .link_q_i(link_q),
    .jab_q_i(jab_q), .rdata_o(mgmt_rdata_o), .stat_clr_o(stat_clr)
  );

  // R5
  property fast_jab_p;
    @(posedge clk) disable iff (!rst_sync_n)
      (!jab_q && speed100_i) |=> !jab_q;
  endproperty
  fast_jab_ignored_chk: assert property (fast_jab_p);

  // R10
  property other_read_keeps_p;
    @(posedge clk) disable iff (!rst_sync_n)
      (mgmt_rd_i && mgmt_addr_i != ADDR_STAT && !jabber_i) |=> $stable(jab_q);
  endproperty
  other_read_keeps_chk: assert property (other_read_keeps_p);

  // R11
  property idle_zero_p;
    @(posedge clk) disable iff (!rst_sync_n) !mgmt_rd_i |-> (mgmt_rdata_o == '0);
  endproperty
  idle_zero_chk: assert property (idle_zero_p);

  // R3
  property rearm_p;
    @(posedge clk) disable iff (!rst_sync_n)
      (stat_clr && link_up_i) |=> link_q;
  endproperty
  rearm_chk: assert property (rearm_p);

  // R7
  property const_bits_p;
    @(posedge clk) disable iff (!rst_sync_n)
      (mgmt_rd_i && mgmt_addr_i == ADDR_STAT) |->
        (mgmt_rdata_o[0] && mgmt_rdata_o[3] && mgmt_rdata_o[15:4] == '0);
  endproperty
  const_bits_chk: assert property (const_bits_p);
endmodule

// File: tb/phy_stat_regs_test.sv
module phy_stat_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 1'b0;
  logic jabber = 1'b0;
  logic spd100 = 1'b0;
  logic [4:0] addr = 5'd0;
  logic rd = 1'b0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;
  int m_link = 0;
  int m_jab = 0;

  always #4 clk = ~clk;

  phy_stat_regs uut (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .jabber_i(jabber),
    .speed100_i(spd100), .mgmt_addr_i(addr), .mgmt_rd_i(rd),
    .mgmt_rdata_o(rdata)
  );

  function automatic logic [15:0] expect_rd(int a, bit r);
    if (!r) return 16'h0000;
    if (a == 1) return 16'h0009 | (m_link != 0 ? 16'h0004 : 16'h0) | (m_jab != 0 ? 16'h0002 : 16'h0);
    if (a == 2) return 16'h0181;
    if (a == 3) return 16'hB8B1;
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_link = 0;
      m_jab = 0;
    end else begin
      bit stat_rd;
      stat_rd = rd && (addr == 5'd1);
      if (!link_up) m_link = 0;
      else if (stat_rd) m_link = 1;
      if (jabber && !spd100) m_jab = 1;
      else if (stat_rd) m_jab = 0;
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) check(cur_req, rdata, expect_rd(int'(addr), rd));
  end

  task automatic cyc(bit r, int a, bit l, bit j, bit s);
    @(posedge clk); #1;
    rd = r; addr = 5'(a); link_up = l; jabber = j; spd100 = s;
  endtask

  task automatic probe(string req, logic [15:0] exp);
    @(negedge clk); #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;
    // R1 reset state
    cur_req = "R1";
    cyc(1, 1, 0, 0, 0); probe("R1", 16'h0009);
    // R11 idle with address pointing at status
    cur_req = "R11";
    cyc(0, 1, 0, 0, 0); probe("R11", 16'h0000);
    // R3 link comes up, first read shows old 0, then 1
    cur_req = "R3";
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0); probe("R3", 16'h0009);
    cyc(1, 1, 1, 0, 0); probe("R3", 16'h000D);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0); probe("R3", 16'h000D);
    // R2 link drop and return between reads
    cur_req = "R2";
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0); probe("R2", 16'h0009);
    cyc(1, 1, 1, 0, 0); probe("R2", 16'h000D);
    // R4 jabber at 10 Mb/s sticks until read
    cur_req = "R4";
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 1, 0, 0); probe("R4", 16'h000F);
    cyc(1, 1, 1, 0, 0); probe("R4", 16'h000D);
    // R5 jabber ignored at 100 Mb/s
    cur_req = "R5";
    cyc(0, 0, 1, 1, 1);
    cyc(0, 0, 1, 1, 1);
    cyc(1, 1, 1, 1, 1); probe("R5", 16'h000D);
    cyc(1, 1, 1, 0, 1); probe("R5", 16'h000D);
    // R6 events coincide with status read
    cur_req = "R6";
    cyc(1, 1, 1, 1, 0); probe("R6", 16'h000D);
    cyc(1, 1, 1, 0, 0); probe("R6", 16'h000F);
    cyc(1, 1, 0, 0, 0); probe("R6", 16'h000D);
    cyc(1, 1, 1, 0, 0); probe("R6", 16'h0009);
    cyc(1, 1, 1, 0, 0); probe("R6", 16'h000D);
    // R8 / R9 identifiers
    cur_req = "R8";
    cyc(1, 2, 1, 0, 0); probe("R8", 16'h0181);
    cur_req = "R9";
    cyc(1, 3, 1, 0, 0); probe("R9", 16'hB8B1);
    // R10 reads elsewhere keep latches
    cur_req = "R10";
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(1, 2, 1, 0, 0); probe("R10", 16'h0181);
    cyc(1, 3, 1, 0, 0); probe("R10", 16'hB8B1);
    cyc(1, 0, 1, 0, 0); probe("R10", 16'h0000);
    for (int a = 4; a < 32; a++) begin
      cyc(1, a, 1, 0, 0); probe("R10", 16'h0000);
    end
    cyc(1, 1, 1, 0, 0); probe("R10", 16'h000B);
    // R7 constant bits seen in every status read above and here
    cur_req = "R7";
    cyc(1, 1, 1, 0, 0); probe("R7", 16'h000D);
    cyc(1, 1, 0, 0, 0); probe("R7", 16'h000D);
    cyc(1, 1, 0, 0, 0); probe("R7", 16'h0009);
    // R1 reset clears a set jabber bit
    cur_req = "R1";
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 1, 0, 0);
    cmp_on = 1'b0;
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cmp_on = 1'b1;
    cyc(1, 1, 1, 0, 0); probe("R1", 16'h0009);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule